// File: doc/BRIEF.md
# Write-Enable and Block-Protect Unit

This block holds the programming-enable latch and the two protection-level bits of a small serial EEPROM. It also assembles the status byte a host reads back, and it judges whether a candidate write address is open for programming. The serial front end issues single-cycle command strobes: enable, disable, status write with a data byte, and programming-cycle finished. It also supplies the write-protect pin level, the busy flag of the programming timer, and a 9-bit address to test.

The array size is a parameter (128, 256 or 512 bytes). The protection level covers the upper quarter, the upper half or the whole array. A status write only stages the new level. The level takes effect when the timed programming cycle that follows reports completion. Every completed programming cycle clears the enable latch.

Top module: `prog_guard`

## Requirements
- R1: After reset the status byte reads 0x00 and `wr_permit` is low.
- R2: An enable strobe with `wp_n` high sets the latch, visible in status bit 1 on the next cycle. With `wp_n` low the strobe is ignored.
- R3: A disable strobe clears the latch whatever the `wp_n` level. When enable and disable arrive in the same cycle, disable wins.
- R4: A `prog_done` strobe clears the latch on the next cycle.
- R5: While `busy` is high the status byte reads 0xFF. Enable, disable and status-write strobes given while busy have no effect.
- R6: `wr_permit` is high in the same cycle exactly when `wp_n` is high, the latch is set and `busy` is low.
- R7: A status write is accepted only when `wr_permit` is high. It stages `stat_data[3:2]` as the new level. Status bits 3:2 show the old level until the next `prog_done`, then the staged level. A `prog_done` with nothing staged leaves the level unchanged.
- R8: `addr_protected` follows the level combinationally. Level 0 protects nothing. Level 1 protects the top quarter (0x180–0x1FF for 512 bytes). Level 2 protects the top half (0x100–0x1FF). Level 3 protects every address. Address bits above the array width are ignored.
- R9: When idle, status bits 7:4 and bit 0 read 0. Bit 1 is the latch and bits 3:2 are the level. Bits of `stat_data` other than 3:2 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_set_en | input | 1 | Enable-latch set strobe |
| cmd_clr_en | input | 1 | Enable-latch clear strobe |
| cmd_stat_wr | input | 1 | Status-write strobe |
| stat_data | input | 8 | Status-write data byte |
| prog_done | input | 1 | Programming cycle completed strobe |
| wp_n | input | 1 | Write-protect pin, high allows writes |
| busy | input | 1 | Programming cycle in progress |
| chk_addr | input | 9 | Address to test against protection |
| status_byte | output | 8 | Assembled status byte |
| wr_permit | output | 1 | A write may be accepted now |
| addr_protected | output | 1 | `chk_addr` lies in the protected range |

## Verification
`wr_permit`, `addr_protected` and the all-ones override of the status byte are combinational, so they are due in the same cycle as the input that changes them. Latch and level changes are registered and appear one clock edge after their strobe. The bench drives inputs on the falling edge. It compares all three outputs against its model a nanosecond later, and only then advances the model at the rising edge. A registered effect is therefore first expected in the following comparison, never in the one that applied the strobe.

// File: rtl/prog_guard_pkg.sv
`timescale 1ns/1ps
package prog_guard_pkg;
   typedef enum logic [1:0] {
      PROT_NONE    = 2'b00,
      PROT_QUARTER = 2'b01,
      PROT_HALF    = 2'b10,
      PROT_ALL     = 2'b11
   } prot_lvl_t;

   localparam int STAT_W      = 8;
   localparam int STAT_BUSY   = 0;
   localparam int STAT_WEN    = 1;
   localparam int STAT_LVL_LO = 2;
   localparam int STAT_LVL_HI = 3;
endpackage

// File: rtl/pg_wen_latch.sv
`timescale 1ns/1ps
module pg_wen_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic busy,
   input  logic wp_n,
   input  logic set_req,
   input  logic clr_req,
   input  logic done,
   output logic wen
);
   logic do_set, do_clr;

   assign do_clr = done | (clr_req & ~busy);
   assign do_set = set_req & wp_n & ~busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      wen <= 1'b0;
      else if (do_clr) wen <= 1'b0;
      else if (do_set) wen <= 1'b1;
   end

   // R2: a rising latch needs the pin high in the cycle of the strobe
   p_set_needs_wp_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wen) |-> $past(wp_n) && $past(set_req));

   p_done_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !wen);

   p_busy_freezes_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> $stable(wen));
endmodule

// File: rtl/pg_prot_reg.sv
`timescale 1ns/1ps
module pg_prot_reg
   import prog_guard_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      accept,
   input  logic [1:0] new_lvl,
   input  logic      done,
   output prot_lvl_t lvl
);
   prot_lvl_t staged;
   logic      pending;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl     <= PROT_NONE;
         staged  <= PROT_NONE;
         pending <= 1'b0;
      end else if (done) begin
         if (pending) lvl <= staged;
         pending <= 1'b0;
      end else if (accept) begin
         staged  <= prot_lvl_t'(new_lvl);
         pending <= 1'b1;
      end
   end

   // R7: level only moves on a completion strobe
   p_lvl_only_on_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !done |=> $stable(lvl));
endmodule

// File: rtl/pg_range_chk.sv
`timescale 1ns/1ps
module pg_range_chk
   import prog_guard_pkg::*;
#(
   parameter int ARRAY_BYTES = 512,
   parameter int ADDR_W      = 9
) (
   input  prot_lvl_t          lvl,
   input  logic [ADDR_W-1:0]  addr,
   output logic               hit
);
   localparam int IDX_W = $clog2(ARRAY_BYTES);

   logic [IDX_W-1:0] idx;
   logic [1:0]       top2;

   generate
      if (ADDR_W > IDX_W) begin : g_wide
         logic unused_hi;
         assign unused_hi = ^addr[ADDR_W-1:IDX_W];
         assign idx       = addr[IDX_W-1:0];
      end else begin : g_exact
         assign idx = addr;
      end
   endgenerate

   assign top2 = idx[IDX_W-1 -: 2];

   always_comb begin
      unique case (lvl)
         PROT_NONE:    hit = 1'b0;
         PROT_QUARTER: hit = (top2 == 2'b11);
         PROT_HALF:    hit = top2[1];
         PROT_ALL:     hit = 1'b1;
         default:      hit = 1'b0;
      endcase
   end
endmodule

// File: rtl/prog_guard.sv
`timescale 1ns/1ps
module prog_guard
   import prog_guard_pkg::*;
#(
   parameter int ARRAY_BYTES = 512,
   parameter int ADDR_W      = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_set_en,
   input  logic              cmd_clr_en,
   input  logic              cmd_stat_wr,
   input  logic [7:0]        stat_data,
   input  logic              prog_done,
   input  logic              wp_n,
   input  logic              busy,
   input  logic [ADDR_W-1:0] chk_addr,
   output logic [7:0]        status_byte,
   output logic              wr_permit,
   output logic              addr_protected
);
   localparam int IDX_W = $clog2(ARRAY_BYTES);

   generate
      if (ARRAY_BYTES != 128 && ARRAY_BYTES != 256 && ARRAY_BYTES != 512) begin : g_bad_size
         $error("prog_guard: ARRAY_BYTES must be 128, 256 or 512");
      end
      if (ADDR_W < IDX_W) begin : g_bad_addr
         $error("prog_guard: ADDR_W too narrow for ARRAY_BYTES");
      end
   endgenerate

   logic      wen;
   logic      stat_accept;
   prot_lvl_t lvl;

   pg_wen_latch u_latch (
      .clk     (clk),
      .rst_n   (rst_n),
      .busy    (busy),
      .wp_n    (wp_n),
      .set_req (cmd_set_en),
      .clr_req (cmd_clr_en),
      .done    (prog_done),
      .wen     (wen)
   );

   assign wr_permit   = wp_n & wen & ~busy;
   assign stat_accept = cmd_stat_wr & wr_permit;

   pg_prot_reg u_prot (
      .clk     (clk),
      .rst_n   (rst_n),
      .accept  (stat_accept),
      .new_lvl (stat_data[STAT_LVL_HI:STAT_LVL_LO]),
      .done    (prog_done),
      .lvl     (lvl)
   );

   pg_range_chk #(
      .ARRAY_BYTES (ARRAY_BYTES),
      .ADDR_W      (ADDR_W)
   ) u_range (
      .lvl  (lvl),
      .addr (chk_addr),
      .hit  (addr_protected)
   );

   always_comb begin
      if (busy) begin
         status_byte = '1;
      end else begin
         status_byte = '0;
         status_byte[STAT_WEN] = wen;
         status_byte[STAT_LVL_HI:STAT_LVL_LO] = lvl;
      end
   end

   p_permit_shows_wen_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_permit |-> status_byte[STAT_WEN] && wp_n);

   p_all_covers_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && status_byte[STAT_LVL_HI:STAT_LVL_LO] == 2'b11) |-> addr_protected);

   p_none_free_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && status_byte[STAT_LVL_HI:STAT_LVL_LO] == 2'b00) |-> !addr_protected);

   p_idle_upper_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> status_byte[7:4] == 4'h0 && !status_byte[STAT_BUSY]);
endmodule

// File: tb/prog_guard_test.sv
`timescale 1ns/1ps
module prog_guard_test;
   localparam int N = 512;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_set_en = 1'b0, cmd_clr_en = 1'b0, cmd_stat_wr = 1'b0;
   logic [7:0] stat_data = 8'h00;
   logic       prog_done = 1'b0, wp_n = 1'b0, busy = 1'b0;
   logic [8:0] chk_addr = 9'h000;
   logic [7:0] status_byte;
   logic       wr_permit, addr_protected;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 0;

   int m_wen = 0, m_bp = 0, m_pend = 0, m_stage = 0;

   always #2.5 clk = ~clk;

   prog_guard #(.ARRAY_BYTES(N), .ADDR_W(9)) uut (
      .clk(clk), .rst_n(rst_n), .cmd_set_en(cmd_set_en), .cmd_clr_en(cmd_clr_en),
      .cmd_stat_wr(cmd_stat_wr), .stat_data(stat_data), .prog_done(prog_done),
      .wp_n(wp_n), .busy(busy), .chk_addr(chk_addr), .status_byte(status_byte),
      .wr_permit(wr_permit), .addr_protected(addr_protected)
   );

   function automatic bit ref_prot(int bp, int a);
      int r = a % N;
      case (bp)
         1:       return r >= (3 * N) / 4;
         2:       return r >= N / 2;
         3:       return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   task automatic check(input string tag, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
      end
   endtask

   task automatic cyc(input logic s, input logic c, input logic sw, input logic [7:0] d,
                      input logic dn, input logic w, input logic b, input logic [8:0] a,
                      input string tag);
      int exp_stat, exp_perm;
      @(negedge clk);
      cmd_set_en = s; cmd_clr_en = c; cmd_stat_wr = sw; stat_data = d;
      prog_done = dn; wp_n = w; busy = b; chk_addr = a;
      #1;
      exp_perm = (w && m_wen != 0 && !b) ? 1 : 0;
      exp_stat = b ? 8'hFF : (m_bp * 4 + m_wen * 2);
      check(tag, "status_byte", int'(status_byte), exp_stat);
      check(tag, "wr_permit", int'(wr_permit), exp_perm);
      check(tag, "addr_protected", int'(addr_protected), int'(ref_prot(m_bp, int'(a))));
      @(posedge clk);
      if (dn) begin
         m_wen = 0;
         if (m_pend != 0) m_bp = m_stage;
         m_pend = 0;
      end else begin
         if (sw && exp_perm != 0) begin
            m_stage = int'(d[3:2]);
            m_pend = 1;
         end
         if (!b) begin
            if (c) m_wen = 0;
            else if (s && w) m_wen = 1;
         end
      end
   endtask

   task automatic idle(input logic w, input logic [8:0] a, input string tag);
      cyc(0, 0, 0, 8'h00, 0, w, 0, a, tag);
   endtask

   // full status-write sequence that programs a level
   task automatic program_level(input logic [7:0] d, input string tag);
      cyc(1, 0, 0, 8'h00, 0, 1, 0, 9'h000, tag);
      cyc(0, 0, 1, d,     0, 1, 0, 9'h000, tag);
      idle(1, 9'h1FF, tag);
      cyc(0, 0, 0, 8'h00, 0, 1, 1, 9'h000, tag);
      cyc(0, 0, 0, 8'h00, 1, 1, 1, 9'h000, tag);
      idle(1, 9'h000, tag);
   endtask

   initial begin
      #(200000 * 5);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      idle(1, 9'h000, "R1");
      idle(0, 9'h1FF, "R1");

      // R2: enable ignored with pin low, taken with pin high
      cyc(1, 0, 0, 8'h00, 0, 0, 0, 9'h000, "R2");
      idle(1, 9'h000, "R2");
      cyc(1, 0, 0, 8'h00, 0, 1, 0, 9'h000, "R2");
      idle(1, 9'h000, "R2");

      // R6: permit follows pin and busy in the same cycle
      idle(0, 9'h000, "R6");
      cyc(0, 0, 0, 8'h00, 0, 1, 1, 9'h000, "R6");
      idle(1, 9'h000, "R6");

      // R3: disable with pin low; simultaneous set and clear
      cyc(0, 1, 0, 8'h00, 0, 0, 0, 9'h000, "R3");
      idle(1, 9'h000, "R3");
      cyc(1, 0, 0, 8'h00, 0, 1, 0, 9'h000, "R3");
      cyc(1, 1, 0, 8'h00, 0, 1, 0, 9'h000, "R3");
      idle(1, 9'h000, "R3");

      // R7: status write refused without the latch
      cyc(0, 0, 1, 8'h0C, 0, 1, 0, 9'h000, "R7");
      cyc(0, 0, 0, 8'h00, 1, 1, 1, 9'h000, "R7");
      idle(1, 9'h000, "R7");

      // R7/R5/R4: accepted write stays staged while busy; commands ignored
      cyc(1, 0, 0, 8'h00, 0, 1, 0, 9'h000, "R7");
      cyc(0, 0, 1, 8'hF7, 0, 1, 0, 9'h000, "R9");
      idle(1, 9'h1FF, "R7");
      cyc(0, 1, 0, 8'h00, 0, 1, 1, 9'h000, "R5");
      cyc(0, 0, 1, 8'h0C, 0, 1, 1, 9'h000, "R5");
      cyc(0, 0, 0, 8'h00, 0, 1, 1, 9'h000, "R5");
      cyc(0, 0, 0, 8'h00, 1, 1, 1, 9'h000, "R4");
      idle(1, 9'h17F, "R8");
      idle(1, 9'h180, "R8");
      idle(1, 9'h1FF, "R8");

      // R5: enable strobe while busy ignored
      cyc(1, 0, 0, 8'h00, 0, 1, 1, 9'h000, "R5");
      idle(1, 9'h000, "R5");

      // R8: half, all, none
      program_level(8'h08, "R8");
      idle(1, 9'h0FF, "R8");
      idle(1, 9'h100, "R8");
      idle(1, 9'h000, "R8");
      program_level(8'h0C, "R8");
      idle(1, 9'h000, "R8");
      idle(1, 9'h0AA, "R8");

      // R7: data-write completion with nothing staged keeps the level
      cyc(1, 0, 0, 8'h00, 0, 1, 0, 9'h000, "R7");
      cyc(0, 0, 0, 8'h00, 0, 1, 1, 9'h000, "R7");
      cyc(0, 0, 0, 8'h00, 1, 1, 1, 9'h000, "R4");
      idle(1, 9'h000, "R7");

      program_level(8'hF3, "R8");
      for (int i = 0; i < 16; i++) idle(1, 9'(i * 32 + 31), "R8");

      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule